// File: doc/BRIEF.md
# Floppy Controller Data-Port Phase Sequencer

This block steers the host-facing data port of a floppy disk controller through its three protocol phases. While idle it is in the command phase: the host writes an opcode byte and then the parameter bytes that opcode needs. The bytes are kept in a small buffer that the command engine can read. When the last parameter has arrived, the sequencer enters the execution phase. There a payload moves either by DMA, with the port closed to the host, or by programmed writes from the host through the port. When the payload is done, the sequencer either opens a result phase, in which the host reads status bytes, or goes straight back to the command phase.

The drive mechanics, the DMA controller and the meaning of each command are outside this block. They are replaced by a parameter-count lookup on the opcode, by execution inputs that are sampled when execution begins (transfer mode, payload length, result length) and by a result-byte input that is indexed by the block's own read pointer. The host finds out when it may use the port, and in which direction, from the main status byte.

Top module: `fdc_phase_seq`

## Requirements
- R1: After a synchronous active-low reset the block is in the command phase, `msr` reads 0x80, `irq` is low and `host_rdata` is 0x00. Bits 3..0 of `msr` are always zero.
- R2: Only bits 4..0 of the first command byte select the command. The lookup gives the number of parameters: 0x08 takes 0, 0x04, 0x07 and 0x0A take 1, 0x03 and 0x0F take 2, 0x05 and 0x06 take 8. Execution begins on the write that delivers the last parameter. For an opcode with no parameters it begins on the opcode write itself.
- R3: `msr` bit 4 (busy) is set from the first command byte until the block is back in the command phase.
- R4: `exec_dma`, `xfer_len` and `res_len` are sampled on the edge that enters execution. In a DMA execution, bit 7 (ready) and bits 6 and 5 are low. Each `dma_ack` cycle moves one byte, and execution ends on the edge of the `xfer_len`-th one. `dma_ack` has no effect in any other phase.
- R5: In a programmed execution, `msr` shows bit 7 and bit 5 set and bit 6 clear. Each host write in that phase is one payload byte and shows on `pio_valid` and `pio_data` in the same cycle. Execution ends on the `xfer_len`-th such write. With `xfer_len` = 0, execution lasts exactly one cycle. Host reads in that phase are ignored.
- R6: At the end of execution the block enters the result phase when the sampled `res_len` is not zero. Otherwise it returns to the command phase (`msr` = 0x80).
- R7: In the result phase `msr` bit 6 (controller to host) and bit 7 are set, `res_idx` starts at 0, and `host_rdata` equals `res_data`. Each host read advances `res_idx`. The read of byte `res_len`-1 returns the block to the command phase.
- R8: An opcode not in the lookup goes straight to the result phase with exactly one result byte, which reads 0x80.
- R9: `irq` rises on entry to the result phase, is high only in that phase, and clears after the first result-byte read.
- R10: A host read in the command phase and a host write in the result phase are ignored: no phase change, no pointer movement.
- R11: Command byte k (the opcode is k = 0) is stored at buffer position k and can be read on `buf_byte` by setting `buf_idx` = k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe to the data port |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe from the data port |
| host_rdata | output | 8 | Byte presented to the host in the result phase |
| msr | output | 8 | Main status: 7 ready, 6 direction, 5 programmed exec, 4 busy |
| irq | output | 1 | Result-phase interrupt |
| exec_dma | input | 1 | Execution mode, 1 = DMA, sampled at execution entry |
| xfer_len | input | XFER_W | Payload length in bytes, sampled at execution entry |
| res_len | input | RES_W | Result byte count, sampled at execution entry |
| res_data | input | 8 | Result byte at position `res_idx` |
| res_idx | output | RES_W | Result read pointer |
| dma_ack | input | 1 | One DMA byte moved this cycle |
| pio_valid | output | 1 | Programmed payload byte accepted this cycle |
| pio_data | output | 8 | Programmed payload byte |
| buf_idx | input | IDX_W | Command buffer read index |
| buf_byte | output | 8 | Command buffer byte at `buf_idx` |

## Verification
The checker watches the relations between the status bits on every cycle: ready low only in DMA execution, the direction and programmed-execution bits never set together, and busy set whenever either is. It also checks that the interrupt is high only in the result phase and drops after a read, and that a write in the result phase leaves the read pointer unchanged. Only the bench's scenarios can show the rest: the parameter counts taken from the opcode lookup, the exact cycle on which execution ends for DMA, programmed and zero-length payloads, the result bytes and their order, the invalid-opcode byte and the buffer contents.

// File: rtl/fdc_seq_pkg.sv
// Shared types and constants for the data-port phase sequencer.
// Assumes an 8-bit host data port.
package fdc_seq_pkg;
    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_EXEC = 2'd1,
        PH_RES  = 2'd2
    } phase_t;

    localparam logic [7:0] INVALID_STATUS = 8'h80;
endpackage

// File: rtl/fdc_cmd_lut.sv
// Opcode lookup: maps bits 4..0 of a command byte to its parameter count.
// Assumes IDX_W can hold the largest count (8).
module fdc_cmd_lut #(
    parameter int IDX_W = 4
) (
    input  logic [7:0]       opcode,
    output logic             known,
    output logic [IDX_W-1:0] nparam
);
    // Decode the command field; upper bits are option flags and ignored.
    always_comb begin
        known  = 1'b1;
        nparam = '0;
        unique case (opcode[4:0])
            5'h08:               nparam = IDX_W'(0);
            5'h04, 5'h07, 5'h0A: nparam = IDX_W'(1);
            5'h03, 5'h0F:        nparam = IDX_W'(2);
            5'h05, 5'h06:        nparam = IDX_W'(8);
            default:             known  = 1'b0;
        endcase
    end
endmodule

// File: rtl/fdc_down_count.sv
// Loadable down counter with zero and one flags; holds at zero.
module fdc_down_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero,
    output logic         is_one
);
    logic [W-1:0] cnt;

    // Load has priority over decrement; the count never wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign is_zero = (cnt == '0);
    assign is_one  = (cnt == W'(1));
endmodule

// File: rtl/fdc_cmd_buf.sv
// Command byte store: one write port, one asynchronous read port.
// Contents are not reset; only positions written since reset are meaningful.
module fdc_cmd_buf #(
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] ridx,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Store a command or parameter byte at its position.
    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/fdc_phase_seq.sv
// Data-port phase sequencer: command -> execution -> (result) -> command.
// Assumes BUF_DEPTH >= 9 (opcode plus up to eight parameters) and that
// execution inputs are stable on the edge that enters execution.
module fdc_phase_seq
    import fdc_seq_pkg::*;
#(
    parameter int XFER_W    = 16,
    parameter int RES_MAX   = 7,
    parameter int BUF_DEPTH = 16,
    localparam int RES_W    = $clog2(RES_MAX + 1),
    localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    input  logic              host_rd,
    output logic [7:0]        host_rdata,
    output logic [7:0]        msr,
    output logic              irq,
    input  logic              exec_dma,
    input  logic [XFER_W-1:0] xfer_len,
    input  logic [RES_W-1:0]  res_len,
    input  logic [7:0]        res_data,
    output logic [RES_W-1:0]  res_idx,
    input  logic              dma_ack,
    output logic              pio_valid,
    output logic [7:0]        pio_data,
    input  logic [IDX_W-1:0]  buf_idx,
    output logic [7:0]        buf_byte
);
    phase_t             phase;
    logic               busy, dma_mode, inval;
    logic [IDX_W-1:0]   pos, need;
    logic [RES_W-1:0]   rlen, ptr;
    logic               lut_known;
    logic [IDX_W-1:0]   lut_n;
    logic               x_zero, x_one;
    logic               to_exec, to_res, to_res_bad, to_cmd, moved, x_done;

    fdc_cmd_lut #(.IDX_W(IDX_W)) u_lut (
        .opcode (host_wdata),
        .known  (lut_known),
        .nparam (lut_n)
    );

    fdc_cmd_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .we    (phase == PH_CMD && host_wr),
        .widx  (pos),
        .wdata (host_wdata),
        .ridx  (buf_idx),
        .rdata (buf_byte)
    );

    fdc_down_count #(.W(XFER_W)) u_xcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (to_exec),
        .load_val (xfer_len),
        .dec      (phase == PH_EXEC && moved),
        .is_zero  (x_zero),
        .is_one   (x_one)
    );

    // Decide the phase transitions taken at the next edge.
    always_comb begin
        moved      = dma_mode ? dma_ack : host_wr;
        x_done     = x_zero || (moved && x_one);
        to_exec    = 1'b0;
        to_res     = 1'b0;
        to_res_bad = 1'b0;
        to_cmd     = 1'b0;
        unique case (phase)
            PH_CMD: if (host_wr) begin
                if (pos == '0) begin
                    to_res_bad = !lut_known;
                    to_exec    = lut_known && (lut_n == '0);
                end else begin
                    to_exec    = (pos == need);
                end
            end
            PH_EXEC: begin
                to_res = x_done && (rlen != '0);
                to_cmd = x_done && (rlen == '0);
            end
            PH_RES:  to_cmd = host_rd && (ptr == rlen - 1'b1);
            default: to_cmd = 1'b1;
        endcase
    end

    // Phase register and per-phase bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_CMD;
            busy     <= 1'b0;
            dma_mode <= 1'b0;
            inval    <= 1'b0;
            pos      <= '0;
            need     <= '0;
            rlen     <= '0;
            ptr      <= '0;
            irq      <= 1'b0;
        end else if (to_cmd) begin
            phase <= PH_CMD;
            busy  <= 1'b0;
            inval <= 1'b0;
            pos   <= '0;
            ptr   <= '0;
            irq   <= 1'b0;
        end else if (to_res_bad) begin
            phase <= PH_RES;
            busy  <= 1'b1;
            inval <= 1'b1;
            rlen  <= RES_W'(1);
            ptr   <= '0;
            irq   <= 1'b1;
        end else if (to_res) begin
            phase <= PH_RES;
            inval <= 1'b0;
            ptr   <= '0;
            irq   <= 1'b1;
        end else if (to_exec) begin
            phase    <= PH_EXEC;
            busy     <= 1'b1;
            dma_mode <= exec_dma;
            rlen     <= res_len;
        end else if (phase == PH_CMD && host_wr) begin
            busy <= 1'b1;
            pos  <= pos + 1'b1;
            if (pos == '0) need <= lut_n;
        end else if (phase == PH_RES && host_rd) begin
            ptr <= ptr + 1'b1;
            irq <= 1'b0;
        end
    end

    // Status byte and port outputs derived from phase and mode.
    always_comb begin
        msr        = 8'h00;
        msr[7]     = !(phase == PH_EXEC && dma_mode);
        msr[6]     = (phase == PH_RES);
        msr[5]     = (phase == PH_EXEC) && !dma_mode;
        msr[4]     = busy;
        host_rdata = (phase == PH_RES) ? (inval ? INVALID_STATUS : res_data) : 8'h00;
        pio_valid  = (phase == PH_EXEC) && !dma_mode && host_wr && !x_zero;
        pio_data   = host_wdata;
        res_idx    = ptr;
    end
endmodule

// File: rtl/fdc_phase_seq_chk.sv
// Cycle-by-cycle property checker for the phase sequencer, bound to the top.
module fdc_phase_seq_chk #(
    parameter int RES_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       msr,
    input logic             irq,
    input logic             host_rd,
    input logic             host_wr,
    input logic [RES_W-1:0] res_idx
);
    a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        msr[3:0] == 4'h0);

    a_r4_dma_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !msr[7] |-> (!msr[6] && !msr[5] && msr[4]));

    a_r5_pio_flags: assert property (@(posedge clk) disable iff (!rst_n)
        msr[5] |-> (msr[7] && !msr[6] && msr[4]));

    a_r7_result_flags: assert property (@(posedge clk) disable iff (!rst_n)
        msr[6] |-> (msr[7] && !msr[5] && msr[4]));

    a_r3_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (msr[7:4] == 4'h8) |-> (res_idx == '0 && !irq));

    a_r9_irq_in_result: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> msr[6]);

    a_r9_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && host_rd) |=> !irq);

    a_r10_write_in_result: assert property (@(posedge clk) disable iff (!rst_n)
        (msr[6] && host_wr && !host_rd) |=> ($stable(res_idx) && msr[6]));
endmodule

bind fdc_phase_seq fdc_phase_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .msr     (msr),
    .irq     (irq),
    .host_rd (host_rd),
    .host_wr (host_wr),
    .res_idx (res_idx)
);

// File: tb/tb_fdc_phase_seq.sv
// Scoreboard bench: driver tasks queue expected result and payload bytes,
// a monitor pops and compares them as the port produces them.
module tb_fdc_phase_seq;
    localparam int XFER_W = 16;
    localparam int RES_W  = 3;
    localparam int IDX_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0, host_rd = 1'b0, exec_dma = 1'b0, dma_ack = 1'b0;
    logic [7:0]        host_wdata = 8'h00;
    logic [XFER_W-1:0] xfer_len = '0;
    logic [RES_W-1:0]  res_len = '0;
    logic [IDX_W-1:0]  buf_idx = '0;
    logic [7:0]        host_rdata, msr, res_data, pio_data, buf_byte;
    logic              irq, pio_valid;
    logic [RES_W-1:0]  res_idx;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    byte unsigned res_q[$];
    byte unsigned pio_q[$];

    always #10 clk = ~clk;

    // Result-byte stand-in: a fixed pattern indexed by the read pointer.
    assign res_data = 8'hC0 | {5'b0, res_idx};

    fdc_phase_seq dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .msr(msr), .irq(irq),
        .exec_dma(exec_dma), .xfer_len(xfer_len), .res_len(res_len),
        .res_data(res_data), .res_idx(res_idx), .dma_ack(dma_ack),
        .pio_valid(pio_valid), .pio_data(pio_data), .buf_idx(buf_idx),
        .buf_byte(buf_byte)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk); host_wr = 1'b1; host_wdata = b;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic pio_wr(input logic [7:0] b);
        pio_q.push_back(b);
        wr(b);
    endtask

    task automatic rd_exp(input logic [7:0] exp);
        res_q.push_back(exp);
        @(negedge clk); host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic rd_raw();
        @(negedge clk); host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic dma_pulse();
        @(negedge clk); dma_ack = 1'b1;
        @(negedge clk); dma_ack = 1'b0;
    endtask

    // Monitor: compare result reads and payload bytes against the queues.
    always @(posedge clk) begin
        if (rst_n && host_rd && msr[6]) begin
            checks++;
            if (res_q.size() == 0) begin
                errors++;
                $display("FAIL R7 unexpected result read: got %h expected none", host_rdata);
            end else begin
                byte unsigned e;
                e = res_q.pop_front();
                if (host_rdata !== e) begin
                    errors++;
                    $display("FAIL R7 result byte: got %h expected %h", host_rdata, e);
                end
            end
        end
        if (rst_n && pio_valid) begin
            checks++;
            if (pio_q.size() == 0) begin
                errors++;
                $display("FAIL R5 unexpected payload: got %h expected none", pio_data);
            end else begin
                byte unsigned e;
                e = pio_q.pop_front();
                if (pio_data !== e) begin
                    errors++;
                    $display("FAIL R5 payload byte: got %h expected %h", pio_data, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check8("R1 msr", msr, 8'h80);
        check8("R1 irq", {7'b0, irq}, 8'h00);
        check8("R1 rdata", host_rdata, 8'h00);

        // R10 read in command phase ignored
        rd_raw();
        check8("R10 read in command", msr, 8'h80);
        // R4 dma_ack outside execution ignored
        dma_pulse();
        check8("R4 dma_ack idle", msr, 8'h80);

        // R2 zero-parameter opcode, R5 zero-length programmed execution
        exec_dma = 1'b0; xfer_len = 0; res_len = 3'd2;
        wr(8'h08);
        check8("R5 zero-length exec msr", msr, 8'hB0);
        @(negedge clk);
        check8("R6 enter result msr", msr, 8'hD0);
        check8("R9 irq set", {7'b0, irq}, 8'h01);
        wr(8'h55);
        check8("R10 write in result idx", {5'b0, res_idx}, 8'h00);
        check8("R10 write in result msr", msr, 8'hD0);
        rd_exp(8'hC0);
        check8("R9 irq cleared", {7'b0, irq}, 8'h00);
        check8("R7 idx advanced", {5'b0, res_idx}, 8'h01);
        rd_exp(8'hC1);
        check8("R7 back to command", msr, 8'h80);

        // R2 two parameters, R4 DMA execution, R6 no result
        exec_dma = 1'b1; xfer_len = 3; res_len = 3'd0;
        wr(8'hE3);
        check8("R3 busy after opcode", msr, 8'h90);
        wr(8'h11);
        check8("R2 still command after p1", msr, 8'h90);
        wr(8'h22);
        check8("R4 dma exec msr", msr, 8'h10);
        dma_pulse(); dma_pulse();
        check8("R4 dma exec after two", msr, 8'h10);
        dma_pulse();
        check8("R6 dma done to command", msr, 8'h80);
        buf_idx = 4'd0; #1 check8("R11 buf opcode", buf_byte, 8'hE3);
        buf_idx = 4'd1; #1 check8("R11 buf p1", buf_byte, 8'h11);
        buf_idx = 4'd2; #1 check8("R11 buf p2", buf_byte, 8'h22);

        // R2 eight parameters, R5 programmed payload, R7 long result
        exec_dma = 1'b0; xfer_len = 4; res_len = 3'd7;
        wr(8'hC5);
        for (int i = 1; i < 8; i++) wr(8'(i));
        check8("R2 still command after 7 params", msr, 8'h90);
        wr(8'h08);
        check8("R5 pio exec msr", msr, 8'hB0);
        rd_raw();
        check8("R5 read in pio exec ignored", msr, 8'hB0);
        pio_wr(8'hA1); pio_wr(8'hA2); pio_wr(8'hA3);
        check8("R5 exec after three", msr, 8'hB0);
        pio_wr(8'hA4);
        check8("R6 pio done to result", msr, 8'hD0);
        for (int i = 0; i < 7; i++) rd_exp(8'hC0 | 8'(i));
        check8("R7 seven reads to command", msr, 8'h80);

        // R8 unknown opcode
        wr(8'h1F);
        check8("R8 invalid to result", msr, 8'hD0);
        check8("R8 irq", {7'b0, irq}, 8'h01);
        rd_exp(8'h80);
        check8("R8 single byte then command", msr, 8'h80);

        // R2 one parameter with DMA and one result byte
        exec_dma = 1'b1; xfer_len = 1; res_len = 3'd1;
        wr(8'h44);
        check8("R2 one-param wait", msr, 8'h90);
        wr(8'h01);
        check8("R4 dma exec entered", msr, 8'h10);
        dma_pulse();
        check8("R6 single dma to result", msr, 8'hD0);
        rd_exp(8'hC0);
        check8("R7 one read to command", msr, 8'h80);

        @(negedge clk);
        checks++;
        if (res_q.size() != 0 || pio_q.size() != 0) begin
            errors++;
            $display("FAIL R7 queues not drained: got %0d expected 0", res_q.size() + pio_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule